// File: doc/BRIEF.md
# Accumulator ALU with status-flag update

This unit produces the result and the carry, signed-overflow and half-carry (nibble carry) updates of an 8-bit accumulator machine. Each cycle it takes an operation class, two operand bytes, the current carry and half-carry, a single boolean operand, and a request to write the status byte directly. One clock later it presents the result and, for each of the three flags, a new value with its own write enable. The surrounding core merges only the enabled flags into its status word.

Each operation class has a fixed policy for each flag. A flag is computed, forced to a constant, or left alone, and a flag that is left alone shows a deasserted enable. A direct write to the status byte, either as a whole byte or one bit at a time, takes priority over the operation class in the same cycle.

Top module: `flag_unit`

## Requirements
- R1: While rst_ni is low, every output is 0, including all three write enables.
- R2: Outputs are registered. A stimulus applied before a rising edge appears after that edge, and not earlier.
- R3: For op_i 1 (add) and 2 (add with carry, cy_i as carry in), res_o[7:0] is the 8-bit sum and res_o[15:8] is 0. C is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed sum leaves -128..127. All three enables are 1.
- R4: For op_i 3 (subtract with borrow, cy_i as borrow in), res_o[7:0] is a-b-cy. C is the borrow out of bit 7, AC is the borrow out of bit 3, and OV marks a signed result outside -128..127. All three enables are 1.
- R5: For op_i 4 (multiply), res_o is the 16-bit product and C is 0. OV is 1 exactly when the product exceeds 255. C and OV are enabled and AC is not.
- R6: For op_i 5 (divide), res_o[7:0] is the quotient and res_o[15:8] is the remainder, with C=0 and OV=0. When b_i is 0, OV is 1 and C is 0, and res_o is unspecified. Only C and OV are enabled.
- R7: For op_i 6 (decimal adjust of a_i), 0x06 is added when the low nibble exceeds 9 or ac_i is 1. 0x60 is then added when the high nibble of that sum exceeds 9 or the carry is set. C is cy_i ORed with any carry out of either addition, and only C is enabled.
- R8: op_i 7 rotates right through carry (res {cy,a[7:1]}, C=a[0]). op_i 8 rotates left through carry (res {a[6:0],cy}, C=a[7]). Only C is enabled.
- R9: op_i 9 sets C to 1, op_i 10 clears C to 0, and op_i 11 sets C to the inverse of cy_i. Only C is enabled and res_o is 0.
- R10: op_i 12 gives C=cy&bit, 13 gives cy&~bit, 14 gives cy|bit, 15 gives cy|~bit, and 16 gives C=bit_i, where bit_i is the boolean operand. Only C is enabled and res_o is 0.
- R11: For op_i 17 (compare), C is 1 exactly when a_i < b_i unsigned. Only C is enabled and res_o is 0.
- R12: With psw_wr_i=1 and psw_bit_i=0, a_i is a status byte. C=a_i[7], AC=a_i[6], OV=a_i[2], all three are enabled, res_o is 0, and op_i is ignored.
- R13: With psw_wr_i=1 and psw_bit_i=1, a_i[2:0] selects a status bit and bit_i is its new value. Index 7 writes C, 6 writes AC, 2 writes OV, and any other index enables no flag. op_i is ignored.
- R14: A flag whose enable is 0 reads 0. op_i 0 and codes 18 to 31 enable no flag and give res_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation class |
| a_i | input | 8 | First operand, status byte, or bit index |
| b_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| bit_i | input | 1 | Boolean operand or status bit value |
| psw_wr_i | input | 1 | Direct status write request |
| psw_bit_i | input | 1 | Direct write is a single bit (1) or a byte (0) |
| res_o | output | 16 | Result |
| c_o | output | 1 | New carry |
| ov_o | output | 1 | New overflow |
| ac_o | output | 1 | New half-carry |
| c_we_o | output | 1 | Carry write enable |
| ov_we_o | output | 1 | Overflow write enable |
| ac_we_o | output | 1 | Half-carry write enable |

## Verification
The bench runs every operation class against the operand values 0x00, 0x09, 0x0A, 0x7F, 0x80, 0x90, 0x99, 0xA0 and 0xFF with both carry-in values. These cover signed overflow across 0x7F/0x80, half-carry at the 9/A nibble step, and divide by zero. A design that took OV from the carry alone would miss these cases, as would one that ignored the borrow into subtraction or let decimal adjust clear an incoming carry. Direct status writes at every bit index check the bit mapping and the priority over the operation. A wrong index, or a flag enabled that should be left alone, shows up at the enable outputs. Unused operation codes are checked to leave every flag alone.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;
  localparam int W   = 8;      // operand width; decimal adjust assumes two nibbles
  localparam int H   = W / 2;
  localparam int RW  = 2 * W;
  localparam int OPW = 5;
  localparam int PSW_C_BIT  = 7;
  localparam int PSW_AC_BIT = 6;
  localparam int PSW_OV_BIT = 2;
  localparam int IDXW = $clog2(W);

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_ADDC  = 5'd2,
    OP_SUBB  = 5'd3,
    OP_MUL   = 5'd4,
    OP_DIV   = 5'd5,
    OP_DA    = 5'd6,
    OP_RRC   = 5'd7,
    OP_RLC   = 5'd8,
    OP_SETC  = 5'd9,
    OP_CLRC  = 5'd10,
    OP_CPLC  = 5'd11,
    OP_ANLC  = 5'd12,
    OP_ANLNC = 5'd13,
    OP_ORLC  = 5'd14,
    OP_ORLNC = 5'd15,
    OP_MOVC  = 5'd16,
    OP_CMP   = 5'd17
  } op_e;

  typedef struct packed {
    logic [RW-1:0] res;
    logic          c;
    logic          ov;
    logic          ac;
    logic          c_we;
    logic          ov_we;
    logic          ac_we;
  } flag_res_t;
endpackage

// File: rtl/flag_arith.sv
module flag_arith
  import flag_unit_pkg::*;
(
  input  op_e              op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             cy_i,
  output flag_res_t        out_o
);
  logic         is_sub;
  logic         cin;
  logic [W:0]   full;
  logic [W-1:0] low;   // MSB is carry/borrow into the top bit
  logic [H:0]   nib;

  always_comb begin
    is_sub = (op_i == OP_SUBB);
    cin    = (op_i == OP_ADD) ? 1'b0 : cy_i;
    if (is_sub) begin
      full = {1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin);
      low  = {1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]} - W'(cin);
      nib  = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - (H+1)'(cin);
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin);
      low  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + W'(cin);
      nib  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + (H+1)'(cin);
    end
    out_o       = '0;
    out_o.res   = RW'(full[W-1:0]);
    out_o.c     = full[W];
    out_o.ac    = nib[H];
    out_o.ov    = low[W-1] ^ full[W];
    out_o.c_we  = 1'b1;
    out_o.ov_we = 1'b1;
    out_o.ac_we = 1'b1;
  end
endmodule

// File: rtl/flag_muldiv.sv
module flag_muldiv
  import flag_unit_pkg::*;
(
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output flag_res_t    out_o
);
  logic [RW-1:0] prod;
  logic [W-1:0]  quo;
  logic [W-1:0]  rem;
  logic          div0;

  always_comb begin
    prod = RW'(a_i) * RW'(b_i);
    div0 = (b_i == '0);
    quo  = div0 ? '0 : a_i / b_i;
    rem  = div0 ? '0 : a_i % b_i;
    out_o       = '0;
    out_o.c     = 1'b0;
    out_o.c_we  = 1'b1;
    out_o.ov_we = 1'b1;
    if (op_i == OP_MUL) begin
      out_o.res = prod;
      out_o.ov  = |prod[RW-1:W];
    end else begin
      out_o.res = {rem, quo};
      out_o.ov  = div0;
    end
  end
endmodule

// File: rtl/flag_misc.sv
module flag_misc
  import flag_unit_pkg::*;
(
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  input  logic         ac_i,
  input  logic         bit_i,
  output flag_res_t    out_o
);
  logic       lo_fix, hi_fix, c_mid;
  logic [W:0] step1, step2;

  // decimal adjust: two conditional nibble corrections, carry only accumulates
  always_comb begin
    lo_fix = (a_i[H-1:0] > H'(9)) || ac_i;
    step1  = {1'b0, a_i} + (lo_fix ? (W+1)'(6) : '0);
    c_mid  = cy_i | step1[W];
    hi_fix = (step1[W-1:H] > H'(9)) || c_mid;
    step2  = {1'b0, step1[W-1:0]} + (hi_fix ? (W+1)'(8'h60) : '0);
  end

  always_comb begin
    out_o = '0;
    case (op_i)
      OP_DA: begin
        out_o.res  = RW'(step2[W-1:0]);
        out_o.c    = c_mid | step2[W];
        out_o.c_we = 1'b1;
      end
      OP_RRC: begin
        out_o.res  = RW'({cy_i, a_i[W-1:1]});
        out_o.c    = a_i[0];
        out_o.c_we = 1'b1;
      end
      OP_RLC: begin
        out_o.res  = RW'({a_i[W-2:0], cy_i});
        out_o.c    = a_i[W-1];
        out_o.c_we = 1'b1;
      end
      OP_SETC:  begin out_o.c = 1'b1;            out_o.c_we = 1'b1; end
      OP_CLRC:  begin out_o.c = 1'b0;            out_o.c_we = 1'b1; end
      OP_CPLC:  begin out_o.c = ~cy_i;           out_o.c_we = 1'b1; end
      OP_ANLC:  begin out_o.c = cy_i & bit_i;    out_o.c_we = 1'b1; end
      OP_ANLNC: begin out_o.c = cy_i & ~bit_i;   out_o.c_we = 1'b1; end
      OP_ORLC:  begin out_o.c = cy_i | bit_i;    out_o.c_we = 1'b1; end
      OP_ORLNC: begin out_o.c = cy_i | ~bit_i;   out_o.c_we = 1'b1; end
      OP_MOVC:  begin out_o.c = bit_i;           out_o.c_we = 1'b1; end
      OP_CMP:   begin out_o.c = (a_i < b_i);     out_o.c_we = 1'b1; end
      default:  out_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [flag_unit_pkg::OPW-1:0] op_i,
  input  logic [flag_unit_pkg::W-1:0]   a_i,
  input  logic [flag_unit_pkg::W-1:0]   b_i,
  input  logic                       cy_i,
  input  logic                       ac_i,
  input  logic                       bit_i,
  input  logic                       psw_wr_i,
  input  logic                       psw_bit_i,
  output logic [flag_unit_pkg::RW-1:0]  res_o,
  output logic                       c_o,
  output logic                       ov_o,
  output logic                       ac_o,
  output logic                       c_we_o,
  output logic                       ov_we_o,
  output logic                       ac_we_o
);
  op_e       op;
  flag_res_t arith_r, muldiv_r, misc_r, psw_r, nxt, q;
  logic [IDXW-1:0] idx;

  assign op  = op_e'(op_i);
  assign idx = a_i[IDXW-1:0];

  flag_arith  u_arith  (.op_i(op), .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .out_o(arith_r));
  flag_muldiv u_muldiv (.op_i(op), .a_i(a_i), .b_i(b_i), .out_o(muldiv_r));
  flag_misc   u_misc   (.op_i(op), .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i),
                        .bit_i(bit_i), .out_o(misc_r));

  // direct status write
  always_comb begin
    psw_r = '0;
    if (!psw_bit_i) begin
      psw_r.c     = a_i[PSW_C_BIT];
      psw_r.ac    = a_i[PSW_AC_BIT];
      psw_r.ov    = a_i[PSW_OV_BIT];
      psw_r.c_we  = 1'b1;
      psw_r.ac_we = 1'b1;
      psw_r.ov_we = 1'b1;
    end else begin
      if (idx == IDXW'(PSW_C_BIT))  begin psw_r.c  = bit_i; psw_r.c_we  = 1'b1; end
      if (idx == IDXW'(PSW_AC_BIT)) begin psw_r.ac = bit_i; psw_r.ac_we = 1'b1; end
      if (idx == IDXW'(PSW_OV_BIT)) begin psw_r.ov = bit_i; psw_r.ov_we = 1'b1; end
    end
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: nxt = arith_r;
      OP_MUL, OP_DIV:           nxt = muldiv_r;
      default:                  nxt = misc_r;
    endcase
    if (psw_wr_i) nxt = psw_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign res_o   = q.res;
  assign c_o     = q.c;
  assign ov_o    = q.ov;
  assign ac_o    = q.ac;
  assign c_we_o  = q.c_we;
  assign ov_we_o = q.ov_we;
  assign ac_we_o = q.ac_we;

  assert_mul_no_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_MUL) |=> (c_we_o && !c_o && ov_we_o && !ac_we_o));

  assert_div_zero_ov_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_DIV && b_i == '0) |=> (ov_o && !c_o && !ac_we_o));

  assert_da_keeps_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_DA && cy_i) |=> (c_o && c_we_o && !ov_we_o && !ac_we_o));

  assert_setc_only_c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_SETC) |=> (c_o && c_we_o && !ov_we_o && !ac_we_o));

  assert_cmp_carry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_CMP) |=> (c_o == $past(a_i < b_i) && !ov_we_o && !ac_we_o));

  assert_bit_write_one_flag_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr_i && psw_bit_i) |=> $countones({c_we_o, ov_we_o, ac_we_o}) <= 1);

  assert_nop_idle_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_wr_i && op_i == OP_NOP) |=> !(c_we_o || ov_we_o || ac_we_o));
endmodule

// File: tb/flag_unit_tb.sv
`timescale 1ns/1ps
module flag_unit_tb;
  localparam int CLK_NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic        cy_i = 0, ac_i = 0, bit_i = 0, psw_wr_i = 0, psw_bit_i = 0;
  logic [15:0] res_o;
  logic        c_o, ov_o, ac_o, c_we_o, ov_we_o, ac_we_o;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  flag_unit u_dut (.*);

  function automatic logic [21:0] ref_model(input int op, input int a, input int b,
      input bit cy, input bit acin, input bit bt, input bit pw, input bit pb);
    int r = 0, t, sa, sb, s, ci;
    bit c = 0, ov = 0, acf = 0, cw = 0, ow = 0, aw = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    ci = (op == 1) ? 0 : int'(cy);
    if (pw && !pb) begin
      c = a[7]; acf = a[6]; ov = a[2]; cw = 1; ow = 1; aw = 1;
    end else if (pw) begin
      case (a % 8)
        7: begin c = bt;   cw = 1; end
        6: begin acf = bt; aw = 1; end
        2: begin ov = bt;  ow = 1; end
        default: ;
      endcase
    end else begin
      case (op)
        1, 2: begin
          s = a + b + ci; r = s % 256; c = s > 255;
          acf = (a % 16 + b % 16 + ci) > 15;
          ov = (sa + sb + ci > 127) || (sa + sb + ci < -128);
          cw = 1; ow = 1; aw = 1;
        end
        3: begin
          s = a - b - ci; r = (s + 512) % 256; c = s < 0;
          acf = (a % 16 - b % 16 - ci) < 0;
          ov = (sa - sb - ci > 127) || (sa - sb - ci < -128);
          cw = 1; ow = 1; aw = 1;
        end
        4: begin r = a * b; c = 0; ov = r > 255; cw = 1; ow = 1; end
        5: begin
          c = 0; cw = 1; ow = 1;
          if (b == 0) ov = 1; else r = (a % b) * 256 + a / b;
        end
        6: begin
          t = a; c = cy;
          if (t % 16 > 9 || acin) begin t += 6; if (t > 255) c = 1; t = t % 256; end
          if (t / 16 > 9 || c) begin t += 96; if (t > 255) c = 1; t = t % 256; end
          r = t; cw = 1;
        end
        7: begin r = int'(cy) * 128 + a / 2; c = a[0]; cw = 1; end
        8: begin r = (a * 2) % 256 + int'(cy); c = a[7]; cw = 1; end
        9:  begin c = 1; cw = 1; end
        10: begin c = 0; cw = 1; end
        11: begin c = !cy; cw = 1; end
        12: begin c = cy && bt; cw = 1; end
        13: begin c = cy && !bt; cw = 1; end
        14: begin c = cy || bt; cw = 1; end
        15: begin c = cy || !bt; cw = 1; end
        16: begin c = bt; cw = 1; end
        17: begin c = a < b; cw = 1; end
        default: ;
      endcase
    end
    return {16'(r), c, ov, acf, cw, ow, aw};
  endfunction

  function automatic string tag_of(input int op, input bit pw, input bit pb);
    if (pw) return pb ? "R13" : "R12";
    case (op)
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R8";
      9, 10, 11: return "R9";
      12, 13, 14, 15, 16: return "R10";
      17: return "R11";
      default: return "R14";
    endcase
  endfunction

  // called at a falling edge; drives, waits one cycle, checks at the next falling edge
  task automatic step(input int op, input int a, input int b, input bit cy,
                      input bit acin, input bit bt, input bit pw, input bit pb);
    logic [21:0] exp_v, act_v, mask;
    op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); cy_i = cy; ac_i = acin;
    bit_i = bt; psw_wr_i = pw; psw_bit_i = pb;
    exp_v = ref_model(op, a, b, cy, acin, bt, pw, pb);
    @(negedge clk_i);
    act_v = {res_o, c_o, ov_o, ac_o, c_we_o, ov_we_o, ac_we_o};
    mask = (!pw && op == 5 && b == 0) ? 22'h00003F : '1;
    n_checks++;
    if ((act_v & mask) !== (exp_v & mask)) begin
      n_err++;
      $display("FAIL %s op=%0d a=%h b=%h cy=%b ac=%b bit=%b pw=%b pb=%b: got %h expected %h",
               tag_of(op, pw, pb), op, a, b, cy, acin, bt, pw, pb, act_v & mask, exp_v & mask);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [21:0] act, input logic [21:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int corner[9] = '{8'h00, 8'h09, 8'h0A, 8'h7F, 8'h80, 8'h90, 8'h99, 8'hA0, 8'hFF};
    logic [21:0] v;
    void'($urandom(32'h5EED1));
    // R1: reset holds outputs at zero even with an active request
    psw_wr_i = 1; a_i = 8'hFF; op_i = 5'd9;
    repeat (3) @(negedge clk_i);
    v = {res_o, c_o, ov_o, ac_o, c_we_o, ov_we_o, ac_we_o};
    chk(v == '0, "R1", v, '0);
    psw_wr_i = 0; op_i = 0; a_i = 0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: output changes only after the next rising edge
    op_i = 5'd1; a_i = 8'hFF; b_i = 8'h01;
    #2;
    v = {res_o, c_o, ov_o, ac_o, c_we_o, ov_we_o, ac_we_o};
    chk(v == '0, "R2", v, '0);
    @(negedge clk_i);
    v = {res_o, c_o, ov_o, ac_o, c_we_o, ov_we_o, ac_we_o};
    chk(v == {16'h0000, 6'b101111}, "R2", v, {16'h0000, 6'b101111});
    // corner operands for every class
    for (int op = 0; op < 18; op++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          for (int cy = 0; cy < 2; cy++)
            step(op, corner[i], corner[j], cy[0], 1'($urandom), 1'($urandom), 0, 0);
    // decimal adjust with incoming half-carry and carry (R7)
    for (int i = 0; i < 9; i++)
      for (int f = 0; f < 4; f++)
        step(6, corner[i], 0, f[1], f[0], 0, 0, 0);
    // unused codes (R14)
    for (int op = 18; op < 32; op++)
      step(op, $urandom % 256, $urandom % 256, 1'($urandom), 1'($urandom), 1'($urandom), 0, 0);
    // direct status writes override op (R12, R13)
    for (int k = 0; k < 40; k++)
      step($urandom % 18, $urandom % 256, $urandom % 256, 1'($urandom), 1'($urandom), 1'($urandom), 1, 0);
    for (int idx = 0; idx < 8; idx++)
      for (int bv = 0; bv < 2; bv++)
        step($urandom % 18, idx + 8 * ($urandom % 32), $urandom % 256, 1'($urandom),
             1'($urandom), bv[0], 1, 1);
    // random mix
    for (int k = 0; k < 4000; k++)
      step($urandom % 20, $urandom % 256, $urandom % 256, 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 16) == 0, 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule